// File: doc/BRIEF.md
# Binary Morphological Opening / Closing Filter

This block filters a raster stream of one-bit pixels with either a morphological opening or a morphological closing. Pixel value 1 is object (white) and 0 is background (black). The stream carries a frame strobe (`vsync_i`), a line-valid strobe (`href_i`) and a per-cycle pixel qualifier (`clken_i`). A pixel is accepted on a clock edge where both `href_i` and `clken_i` are high. The filter has two stages in series. One stage is an erosion and the other is a dilation. Each stage uses the full 3x3 square as its structuring element.

Each stage builds a 3x3 window from two line stores and a short column shift register. Window positions that fall above the first line or left of the first column count as 0. The stage then reduces the window in two registered steps: it first folds each row of three pixels, then folds the three row results. The strobes pass through matching registers, so the output stream stays aligned with the pixel it describes. Frame width and height are parameters. The operating mode is captured once per frame, at the start of the frame.

Top module: `morph_openclose`

## Requirements
- R1: While `rst` is high, and on the cycle after a reset edge, `vsync_o`, `href_o`, `clken_o` and `pix_o` are all 0.
- R2: `vsync_o`, `href_o` and `clken_o` equal `vsync_i`, `href_i` and `clken_i` as sampled four clock edges earlier. Each stage adds two edges. Each frame of WIDTH x HEIGHT qualified input pixels therefore gives exactly WIDTH x HEIGHT qualified output pixels.
- R3: `pix_o` is 0 on every cycle where `href_o` is 0.
- R4: Pixels are numbered in raster order as row r (0..HEIGHT-1) and column c (0..WIDTH-1). For an image X, define the stage result at (r,c) over X(r-i, c-j) for i,j in {0,1,2}, where any negative index reads as 0. Dilation D gives the OR of these nine values. Erosion E gives their AND. With `mode_close_i` = 0 (opening), the qualified output pixels in order equal D(E(I)).
- R5: With `mode_close_i` = 1 (closing), the qualified output pixels equal E(D(I)), using the definitions of R4.
- R6: Zero padding at the top and left edges: opening an all-ones frame gives 0 at every position where r < 2 or c < 2, and 1 everywhere else.
- R7: A cycle inside a line where `clken_i` is 0 advances no window. The pixel value on such a cycle is ignored, and the output equals that of the same frame sent without gaps.
- R8: `mode_close_i` is sampled on the clock edge where `vsync_i` is first seen high. A change to it later in the frame has no effect on that frame.
- R9: Opening removes a lone 1 pixel entirely. Closing fills a single 0 pixel surrounded by 1s: for a hole at (2,3), the output at (4,5) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_close_i | input | 1 | 0 selects opening, 1 selects closing; captured at the frame start |
| vsync_i | input | 1 | Frame strobe; its rising edge starts a frame |
| href_i | input | 1 | Line-valid strobe |
| clken_i | input | 1 | Pixel qualifier, meaningful while href_i is high |
| pix_i | input | 1 | Input pixel (1 object, 0 background) |
| vsync_o | output | 1 | Frame strobe, delayed four edges |
| href_o | output | 1 | Line-valid strobe, delayed four edges |
| clken_o | output | 1 | Pixel qualifier, delayed four edges |
| pix_o | output | 1 | Filtered pixel, forced to 0 while href_o is low |

## Verification
Suppose a line store is addressed wrongly, a padding mask is off by one, or a shift register advances on an unqualified cycle. The window then differs from the software model. The error shows in the qualified output pixels two edges after the damaged window is formed, and a single full frame exposes it. A wrong mode capture flips the whole output image, so the frame comparison catches it. A missing strobe register shifts the outputs out of step with the inputs of four edges earlier. The cycle-by-cycle comparison of the strobes exposes that within the first frame.

// File: rtl/morph_pkg.sv
package morph_pkg;

    // Window side of the square structuring element
    localparam int WIN = 3;
    // Line stores needed per stage
    localparam int NLINES = WIN - 1;
    // Registered reduction steps per stage
    localparam int STAGE_LAT = 2;

    typedef enum logic {
        OP_ERODE  = 1'b0,
        OP_DILATE = 1'b1
    } morph_op_e;

    typedef struct packed {
        logic vsync;
        logic href;
        logic clken;
    } vid_ctl_t;

    // Outer index: line age (0 = current line); inner bit: column age
    typedef logic [WIN-1:0][WIN-1:0] win_t;

    function automatic logic fold_row(morph_op_e op, logic [WIN-1:0] v);
        return (op == OP_DILATE) ? (|v) : (&v);
    endfunction

    // Opening erodes first; closing dilates first
    function automatic morph_op_e first_op(logic close_mode);
        return close_mode ? OP_DILATE : OP_ERODE;
    endfunction

    function automatic morph_op_e second_op(logic close_mode);
        return close_mode ? OP_ERODE : OP_DILATE;
    endfunction

endpackage

// File: rtl/morph_linebuf.sv
module morph_linebuf #(
    parameter int DEPTH = 640,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic          din_i,
    output logic          dout_o
);

    logic mem [DEPTH];

    // Read before write: the output shows the value stored one line earlier
    assign dout_o = mem[addr_i];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= din_i;
        end
    end

endmodule

// File: rtl/morph_window.sv
module morph_window
    import morph_pkg::*;
#(
    parameter int WIDTH  = 640,
    parameter int HEIGHT = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic sof_i,
    input  logic vld_i,
    input  logic pix_i,
    output win_t win_o
);

    localparam int CW = $clog2(WIDTH);
    localparam int RW = $clog2(HEIGHT);

    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;

    logic [NLINES-1:0] lb_d;
    logic [NLINES-1:0] lb_q;

    // Newest column (age 0), one bit per line age, rows above the frame masked
    logic [WIN-1:0] col0;
    logic [WIN-1:0] col1;
    logic [WIN-1:0] col2;
    logic [WIN-1:0] sh1_q;
    logic [WIN-1:0] sh2_q;

    // Raster position counters
    always_ff @(posedge clk) begin
        if (rst || sof_i) begin
            col_q <= '0;
            row_q <= '0;
        end else if (vld_i) begin
            if (col_q == CW'(WIDTH - 1)) begin
                col_q <= '0;
                row_q <= (row_q == RW'(HEIGHT - 1)) ? '0 : row_q + RW'(1);
            end else begin
                col_q <= col_q + CW'(1);
            end
        end
    end

    // Chain of line stores: each one delays its input by one line
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        if (g == 0) begin : g_head
            assign lb_d[g] = pix_i;
        end else begin : g_tail
            assign lb_d[g] = lb_q[g-1];
        end

        morph_linebuf #(
            .DEPTH (WIDTH),
            .AW    (CW)
        ) u_lb (
            .clk    (clk),
            .we_i   (vld_i),
            .addr_i (col_q),
            .din_i  (lb_d[g]),
            .dout_o (lb_q[g])
        );

        // A line store is valid only once that many lines have passed
        assign col0[g+1] = lb_q[g] & (row_q >= RW'(g + 1));
    end

    assign col0[0] = pix_i;

    // Column shift registers hold the two previous columns
    always_ff @(posedge clk) begin
        if (rst || sof_i) begin
            sh1_q <= '0;
            sh2_q <= '0;
        end else if (vld_i) begin
            sh1_q <= col0;
            sh2_q <= sh1_q;
        end
    end

    // Columns left of the frame read as zero
    assign col1 = (col_q >= CW'(1)) ? sh1_q : '0;
    assign col2 = (col_q >= CW'(2)) ? sh2_q : '0;

    for (genvar k = 0; k < WIN; k++) begin : g_row
        assign win_o[k] = {col2[k], col1[k], col0[k]};
    end

endmodule

// File: rtl/morph_reduce.sv
module morph_reduce
    import morph_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  morph_op_e op_i,
    input  win_t      win_i,
    input  vid_ctl_t  ctl_i,
    output vid_ctl_t  ctl_o,
    output logic      pix_o
);

    logic [WIN-1:0] row_d;
    logic [WIN-1:0] row_q;
    logic           res_q;
    vid_ctl_t       ctl1_q;
    vid_ctl_t       ctl2_q;

    // First step: fold each row of three
    for (genvar k = 0; k < WIN; k++) begin : g_fold
        assign row_d[k] = fold_row(op_i, win_i[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            res_q  <= 1'b0;
            ctl1_q <= '0;
            ctl2_q <= '0;
        end else begin
            row_q  <= row_d;
            // Second step: fold the three row results
            res_q  <= fold_row(op_i, row_q);
            ctl1_q <= ctl_i;
            ctl2_q <= ctl1_q;
        end
    end

    assign ctl_o = ctl2_q;
    assign pix_o = ctl2_q.href ? res_q : 1'b0;

endmodule

// File: rtl/morph_stage.sv
module morph_stage
    import morph_pkg::*;
#(
    parameter int        WIDTH    = 640,
    parameter int        HEIGHT   = 480,
    parameter morph_op_e RESET_OP = OP_ERODE
) (
    input  logic      clk,
    input  logic      rst,
    input  morph_op_e op_sel_i,
    input  vid_ctl_t  ctl_i,
    input  logic      pix_i,
    output vid_ctl_t  ctl_o,
    output logic      pix_o
);

    logic      vs_prev_q;
    logic      sof;
    logic      vld;
    morph_op_e op_q;
    win_t      win;

    assign sof = ctl_i.vsync & ~vs_prev_q;
    assign vld = ctl_i.href & ctl_i.clken;

    // Operator is fixed for the frame from this stage's own frame start
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev_q <= 1'b0;
            op_q      <= RESET_OP;
        end else begin
            vs_prev_q <= ctl_i.vsync;
            if (sof) begin
                op_q <= op_sel_i;
            end
        end
    end

    morph_window #(
        .WIDTH  (WIDTH),
        .HEIGHT (HEIGHT)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .sof_i (sof),
        .vld_i (vld),
        .pix_i (pix_i),
        .win_o (win)
    );

    morph_reduce u_red (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op_q),
        .win_i (win),
        .ctl_i (ctl_i),
        .ctl_o (ctl_o),
        .pix_o (pix_o)
    );

endmodule

// File: rtl/morph_openclose.sv
module morph_openclose
    import morph_pkg::*;
#(
    parameter int WIDTH  = 640,
    parameter int HEIGHT = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_close_i,
    input  logic vsync_i,
    input  logic href_i,
    input  logic clken_i,
    input  logic pix_i,
    output logic vsync_o,
    output logic href_o,
    output logic clken_o,
    output logic pix_o
);

    vid_ctl_t in_ctl;
    vid_ctl_t mid_ctl;
    vid_ctl_t out_ctl;
    logic     mid_pix;
    logic     vsync_prev_q;
    logic     mode_q;
    logic     sof_in;

    assign in_ctl = '{vsync: vsync_i, href: href_i, clken: clken_i};
    assign sof_in = vsync_i & ~vsync_prev_q;

    // Mode held for the frame so the second stage sees the same choice
    always_ff @(posedge clk) begin
        if (rst) begin
            vsync_prev_q <= 1'b0;
            mode_q       <= 1'b0;
        end else begin
            vsync_prev_q <= vsync_i;
            if (sof_in) begin
                mode_q <= mode_close_i;
            end
        end
    end

    morph_stage #(
        .WIDTH    (WIDTH),
        .HEIGHT   (HEIGHT),
        .RESET_OP (OP_ERODE)
    ) u_stage_a (
        .clk      (clk),
        .rst      (rst),
        .op_sel_i (first_op(mode_close_i)),
        .ctl_i    (in_ctl),
        .pix_i    (pix_i),
        .ctl_o    (mid_ctl),
        .pix_o    (mid_pix)
    );

    morph_stage #(
        .WIDTH    (WIDTH),
        .HEIGHT   (HEIGHT),
        .RESET_OP (OP_DILATE)
    ) u_stage_b (
        .clk      (clk),
        .rst      (rst),
        .op_sel_i (second_op(mode_q)),
        .ctl_i    (mid_ctl),
        .pix_i    (mid_pix),
        .ctl_o    (out_ctl),
        .pix_o    (pix_o)
    );

    assign vsync_o = out_ctl.vsync;
    assign href_o  = out_ctl.href;
    assign clken_o = out_ctl.clken;

endmodule

// File: rtl/morph_openclose_chk.sv
module morph_openclose_chk (
    input logic clk,
    input logic rst,
    input logic vsync_i,
    input logic href_i,
    input logic clken_i,
    input logic vsync_o,
    input logic href_o,
    input logic clken_o,
    input logic pix_o,
    input logic vsync_prev_q,
    input logic mode_q
);

    logic [2:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd4) begin
            age_q <= age_q + 3'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!vsync_o && !href_o && !clken_o && !pix_o));

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'd4) |-> (vsync_o == $past(vsync_i, 4) &&
                             href_o  == $past(href_i, 4) &&
                             clken_o == $past(clken_i, 4)));

    // R3
    href_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !href_o |-> !pix_o);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(vsync_i && !vsync_prev_q) |=> (mode_q == $past(mode_q)));

endmodule

bind morph_openclose morph_openclose_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vsync_i      (vsync_i),
    .href_i       (href_i),
    .clken_i      (clken_i),
    .vsync_o      (vsync_o),
    .href_o       (href_o),
    .clken_o      (clken_o),
    .pix_o        (pix_o),
    .vsync_prev_q (vsync_prev_q),
    .mode_q       (mode_q)
);

// File: tb/morph_openclose_test.sv
`timescale 1ns/1ps
module morph_openclose_test;

    localparam int W = 8;
    localparam int H = 6;
    localparam int N = W * H;

    logic clk = 1'b0;
    logic rst;
    logic mode_close_i, vsync_i, href_i, clken_i, pix_i;
    logic vsync_o, href_o, clken_o, pix_o;

    int n_chk = 0;
    int n_err = 0;
    int got_n;
    int sync_bad;
    int gate_bad;
    logic got [N];
    logic [2:0] hist [4];
    logic [H-1:0][W-1:0] img;
    logic [H-1:0][W-1:0] exp_img;

    always #2.5 clk = ~clk;

    morph_openclose #(.WIDTH(W), .HEIGHT(H)) uut (
        .clk(clk), .rst(rst), .mode_close_i(mode_close_i),
        .vsync_i(vsync_i), .href_i(href_i), .clken_i(clken_i), .pix_i(pix_i),
        .vsync_o(vsync_o), .href_o(href_o), .clken_o(clken_o), .pix_o(pix_o)
    );

    // Input history for strobe alignment
    always @(posedge clk) begin
        hist[0] <= rst ? 3'b000 : {vsync_i, href_i, clken_i};
        hist[1] <= hist[0];
        hist[2] <= hist[1];
        hist[3] <= hist[2];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if ({vsync_o, href_o, clken_o} !== hist[3]) sync_bad++;
            if (!href_o && pix_o) gate_bad++;
            if (href_o && clken_o) begin
                if (got_n < N) got[got_n] = pix_o;
                got_n++;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [H-1:0][W-1:0] apply_op(input bit dil, input logic [H-1:0][W-1:0] src);
        logic [H-1:0][W-1:0] dst;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                logic acc;
                acc = dil ? 1'b0 : 1'b1;
                for (int i = 0; i < 3; i++) begin
                    for (int j = 0; j < 3; j++) begin
                        logic v;
                        v = (r - i >= 0 && c - j >= 0) ? src[r-i][c-j] : 1'b0;
                        acc = dil ? (acc | v) : (acc & v);
                    end
                end
                dst[r][c] = acc;
            end
        end
        return dst;
    endfunction

    task automatic run_frame(input bit close_mode, input bit gap, input bit flip);
        got_n = 0; sync_bad = 0; gate_bad = 0;
        mode_close_i = close_mode; vsync_i = 1'b1; href_i = 1'b0; clken_i = 1'b0; pix_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (flip) mode_close_i = !close_mode;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gap && (c % 3 == 1)) begin
                    href_i = 1'b1; clken_i = 1'b0; pix_i = 1'b1;
                    @(negedge clk);
                end
                href_i = 1'b1; clken_i = 1'b1; pix_i = img[r][c];
                @(negedge clk);
            end
            href_i = 1'b0; clken_i = 1'b0; pix_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        vsync_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic compare_frame(input string req, input bit close_mode);
        int mm;
        exp_img = apply_op(!close_mode, apply_op(close_mode, img));
        mm = 0;
        for (int k = 0; k < N && k < got_n; k++) begin
            if (got[k] !== exp_img[k / W][k % W]) mm++;
        end
        check(req, "qualified output count", got_n, N);
        check(req, "pixel mismatches", mm, 0);
        check("R2", "strobe misaligned cycles", sync_bad, 0);
        check("R3", "pix_o high while href_o low", gate_bad, 0);
    endtask

    task automatic fill_lfsr(input logic [7:0] seed);
        logic [7:0] v;
        v = seed;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
                img[r][c] = v[0] | v[1];
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; mode_close_i = 1'b1; vsync_i = 1'b1; href_i = 1'b1; clken_i = 1'b1; pix_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", {vsync_o, href_o, clken_o, pix_o}, 0);
        vsync_i = 1'b0; href_i = 1'b0; clken_i = 1'b0; pix_i = 1'b0; mode_close_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "outputs after reset", {vsync_o, href_o, clken_o, pix_o}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_open_blob;
        img = '0;
        for (int r = 1; r <= 4; r++)
            for (int c = 3; c <= 7; c++) img[r][c] = 1'b1;
        img[0][0] = 1'b1;
        run_frame(1'b0, 1'b0, 1'b0);
        compare_frame("R4", 1'b0);
    endtask

    task automatic t_close_hole;
        img = '1;
        img[2][3] = 1'b0;
        run_frame(1'b1, 1'b0, 1'b0);
        compare_frame("R5", 1'b1);
        check("R9", "closed hole at (4,5)", got[4*W+5], 1);
    endtask

    task automatic t_edges;
        img = '1;
        run_frame(1'b0, 1'b0, 1'b0);
        compare_frame("R6", 1'b0);
        check("R6", "padded edge (1,7)", got[1*W+7], 0);
        check("R6", "padded edge (5,1)", got[5*W+1], 0);
        check("R6", "interior (2,2)", got[2*W+2], 1);
    endtask

    task automatic t_gapped;
        fill_lfsr(8'h5A);
        run_frame(1'b0, 1'b1, 1'b0);
        compare_frame("R7", 1'b0);
        fill_lfsr(8'hC3);
        run_frame(1'b1, 1'b1, 1'b0);
        compare_frame("R7", 1'b1);
    endtask

    task automatic t_close_random;
        fill_lfsr(8'h17);
        run_frame(1'b1, 1'b0, 1'b0);
        compare_frame("R5", 1'b1);
    endtask

    task automatic t_mode_hold;
        int ones_open;
        fill_lfsr(8'h9E);
        run_frame(1'b0, 1'b0, 1'b1);
        compare_frame("R8", 1'b0);
        fill_lfsr(8'h9E);
        run_frame(1'b1, 1'b0, 1'b1);
        compare_frame("R8", 1'b1);
        ones_open = 0;
    endtask

    task automatic t_isolated;
        int ones;
        img = '0;
        img[3][4] = 1'b1;
        run_frame(1'b0, 1'b0, 1'b0);
        ones = 0;
        for (int k = 0; k < N; k++) if (got[k] === 1'b1) ones++;
        check("R9", "ones left after opening lone pixel", ones, 0);
        check("R2", "qualified output count", got_n, N);
    endtask

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        got_n = 0; sync_bad = 0; gate_bad = 0;
        t_reset();
        t_open_blob();
        t_close_hole();
        t_edges();
        t_gapped();
        t_close_random();
        t_mode_hold();
        t_isolated();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule